// File: doc/BRIEF.md
# Filtered Pattern-Address Scanline Interrupt Counter

This block sits on the cartridge side of a video system and counts scanlines by watching bit 12 of the picture processor's pattern-fetch address (called A12 here). Every fetch from the upper pattern table drives A12 high. Fetches from the lower table, and palette lookups that stay inside the picture processor, leave it low. So a well-formed rise of A12 marks one scanline. The input is treated as sampled data on the one system clock. It is never used as a clock.

During the sprite-fetch part of a line, A12 toggles in short bursts of about four low and four high cycles. Counting every rise in such a burst would overcount. A qualifier therefore accepts a rise only after A12 has been low for a programmable hold-off, so only the first rise of a burst is taken. Each accepted rise either reloads an 8-bit down-counter from a latch or decrements it. When the counter lands on zero with the interrupt enabled, an active-low request is raised and held until software acknowledges it.

Software programs the block through four write-only registers. One sets the reload value, one forces a reload on the next accepted rise, one turns the interrupt off and clears a pending request, and one turns the interrupt on.

Top module: `scanline_irq_counter`

## Requirements
- R1: A rise is taken only when the A12 sample is 1 in the current cycle and was 0 in the cycle before. A12 held high, held low or falling never changes the counter.
- R2: A rise is accepted only when A12 was sampled low for at least H consecutive cycles just before it. H is `holdoff_cycles` (0..15), and any value below 2 acts as 2. The system default is 8.
- R3: With H = 8, a sprite-style burst of 4-cycle-high / 4-cycle-low toggles gives exactly one accepted rise, the first one. With H = 4, every rise in the burst is accepted.
- R4: While A12 stays low for a whole line, the counter does not change and no interrupt is raised, even with the interrupt enabled.
- R5: On an accepted rise, the counter loads the latch and clears the reload request if the counter is zero or a reload is pending. Otherwise the counter decrements by one.
- R6: When the counter value produced by an accepted rise is zero and the interrupt is enabled, `irq_n` goes low after that clock edge. It stays low until an acknowledge write.
- R7: A write (cpu_we = 1) decodes as follows: `cpu_addr_hi` = 3'b110 with `cpu_addr_lo` = 0 sets the latch from `cpu_wdata`; 3'b110 with lo = 1 requests a reload; 3'b111 with lo = 0 disables the interrupt and clears a pending request (`irq_n` high after that edge); 3'b111 with lo = 1 enables the interrupt. Writes with any other `cpu_addr_hi` are ignored.
- R8: Synchronous reset clears the counter, the latch, the reload request, the enable, the pending interrupt and the low-run (hold-off) count. `irq_n` reads 1 after reset. A rise after reset still needs a full hold-off of low samples.
- R9: If the counter reaches zero while the interrupt is disabled, no request is raised. A later zero, reached after the interrupt is enabled, does raise one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr_hi | input | 3 | CPU address bits 15..13, selects the register window |
| cpu_addr_lo | input | 1 | CPU address bit 0, selects the even or odd register |
| cpu_wdata | input | 8 | CPU write data |
| holdoff_cycles | input | 4 | Minimum low run in cycles before a rise is accepted |
| a12_in | input | 1 | Sampled pattern address bit 12 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Lines of four kinds drive the counter: a single background rise, a sprite-style 4/4 toggle burst, a line with a one-cycle low glitch between two highs, and a line held low throughout. The bench records the line on which the interrupt first fires. Background lines confirm the reload-then-decrement sequence. Burst lines at hold-off 8, 4 and 15 show whether the filter takes one rise or all of them. The glitch line at hold-off 0 shows the floor of two low samples. Lines held low show that the count freezes. Directed cases cover hold-until-acknowledge, a zero reached while disabled, a mid-count reload, ignored addresses, and a rise right after reset that lacks enough low history.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

    localparam int DATA_W   = 8;
    localparam int HOLD_W   = 4;
    localparam int MIN_HOLD = 2;

    typedef enum logic [1:0] {
        REG_LATCH   = 2'b00,
        REG_RELOAD  = 2'b01,
        REG_IRQ_OFF = 2'b10,
        REG_IRQ_ON  = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } cpu_cmd_t;

    function automatic logic [HOLD_W-1:0] clamp_hold(input logic [HOLD_W-1:0] h);
        if (h < HOLD_W'(MIN_HOLD))
            return HOLD_W'(MIN_HOLD);
        return h;
    endfunction

endpackage

// File: rtl/cpu_reg_decode.sv
module cpu_reg_decode
    import scan_irq_pkg::*;
(
    input  logic              cpu_we,
    input  logic [2:0]        cpu_addr_hi,
    input  logic              cpu_addr_lo,
    input  logic [DATA_W-1:0] cpu_wdata,
    output cpu_cmd_t          cmd
);

    logic in_window;

    always_comb begin
        in_window = cpu_addr_hi[2] & cpu_addr_hi[1];
        cmd.valid = cpu_we & in_window;
        cmd.sel   = reg_sel_e'({cpu_addr_hi[0], cpu_addr_lo});
        cmd.data  = cpu_wdata;
    end

endmodule

// File: rtl/a12_rise_qualifier.sv
module a12_rise_qualifier
    import scan_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a12_in,
    input  logic [HOLD_W-1:0] holdoff_cycles,
    output logic              rise
);

    localparam logic [HOLD_W-1:0] RUN_MAX = '1;

    logic              a12_q;
    logic [HOLD_W-1:0] low_run;
    logic [HOLD_W-1:0] eff_hold;

    always_comb begin
        eff_hold = clamp_hold(holdoff_cycles);
        rise     = a12_in & ~a12_q & (low_run >= eff_hold);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a12_q   <= 1'b0;
            low_run <= '0;
        end else begin
            a12_q <= a12_in;
            if (a12_in)
                low_run <= '0;
            else if (low_run != RUN_MAX)
                low_run <= low_run + 1'b1;
        end
    end

endmodule

// File: rtl/scanline_count.sv
module scanline_count
    import scan_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  cpu_cmd_t          cmd,
    output logic [DATA_W-1:0] cnt,
    output logic              reload_pend,
    output logic              irq_en,
    output logic              irq_n
);

    logic [DATA_W-1:0] latch_q;
    logic [DATA_W-1:0] cnt_nxt;
    logic              irq_q;
    logic              ack_wr;

    always_comb begin
        if (cnt == '0 || reload_pend)
            cnt_nxt = latch_q;
        else
            cnt_nxt = cnt - 1'b1;
        ack_wr = cmd.valid && cmd.sel == REG_IRQ_OFF;
        irq_n  = ~irq_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            latch_q     <= '0;
            reload_pend <= 1'b0;
            irq_en      <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            if (cmd.valid) begin
                case (cmd.sel)
                    REG_LATCH:   latch_q     <= cmd.data;
                    REG_RELOAD:  reload_pend <= 1'b1;
                    REG_IRQ_OFF: irq_en      <= 1'b0;
                    REG_IRQ_ON:  irq_en      <= 1'b1;
                    default:     ;
                endcase
            end
            if (rise) begin
                cnt         <= cnt_nxt;
                reload_pend <= 1'b0;
            end
            if (ack_wr)
                irq_q <= 1'b0;
            else if (rise && cnt_nxt == '0 && irq_en)
                irq_q <= 1'b1;
        end
    end

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import scan_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [2:0]        cpu_addr_hi,
    input  logic              cpu_addr_lo,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [HOLD_W-1:0] holdoff_cycles,
    input  logic              a12_in,
    output logic              irq_n
);

    cpu_cmd_t          cmd_w;
    logic              rise_w;
    logic [DATA_W-1:0] cnt_w;
    logic              reload_w;
    logic              irq_en_w;

    cpu_reg_decode u_dec (
        .cpu_we      (cpu_we),
        .cpu_addr_hi (cpu_addr_hi),
        .cpu_addr_lo (cpu_addr_lo),
        .cpu_wdata   (cpu_wdata),
        .cmd         (cmd_w)
    );

    a12_rise_qualifier u_qual (
        .clk            (clk),
        .rst            (rst),
        .a12_in         (a12_in),
        .holdoff_cycles (holdoff_cycles),
        .rise           (rise_w)
    );

    scanline_count u_cnt (
        .clk         (clk),
        .rst         (rst),
        .rise        (rise_w),
        .cmd         (cmd_w),
        .cnt         (cnt_w),
        .reload_pend (reload_w),
        .irq_en      (irq_en_w),
        .irq_n       (irq_n)
    );

endmodule

// File: rtl/scanline_irq_checker.sv
module scanline_irq_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             a12_in,
    input logic             rise,
    input logic [CNT_W-1:0] cnt,
    input logic             reload_pend,
    input logic             irq_en,
    input logic             irq_n,
    input logic             cpu_we,
    input logic [2:0]       cpu_addr_hi,
    input logic             cpu_addr_lo
);

    logic ack_seen;
    assign ack_seen = cpu_we && cpu_addr_hi == 3'b111 && !cpu_addr_lo;

    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
        rise |-> (a12_in && !$past(a12_in))); // R1

    AST_MIN_LOW_RUN: assert property (@(posedge clk) disable iff (rst)
        rise |-> (!$past(a12_in, 1) && !$past(a12_in, 2))); // R2

    AST_FROZEN_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
        !a12_in |=> $stable(cnt)); // R4

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (rise && cnt != '0 && !reload_pend) |=> (cnt == $past(cnt) - 1'b1)); // R5

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !ack_seen) |=> !irq_n); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ack_seen |=> irq_n); // R7

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(irq_en)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (irq_n && cnt == '0 && !irq_en)); // R8

endmodule

bind scanline_irq_counter scanline_irq_checker #(.CNT_W(scan_irq_pkg::DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .a12_in      (a12_in),
    .rise        (rise_w),
    .cnt         (cnt_w),
    .reload_pend (reload_w),
    .irq_en      (irq_en_w),
    .irq_n       (irq_n),
    .cpu_we      (cpu_we),
    .cpu_addr_hi (cpu_addr_hi),
    .cpu_addr_lo (cpu_addr_lo)
);

// File: tb/sim_scanline_irq_counter.sv
module sim_scanline_irq_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_we = 1'b0;
    logic [2:0] cpu_addr_hi = 3'b000;
    logic       cpu_addr_lo = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [3:0] holdoff_cycles = 4'd8;
    logic       a12_in = 1'b0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    scanline_irq_counter u0 (
        .clk            (clk),
        .rst            (rst),
        .cpu_we         (cpu_we),
        .cpu_addr_hi    (cpu_addr_hi),
        .cpu_addr_lo    (cpu_addr_lo),
        .cpu_wdata      (cpu_wdata),
        .holdoff_cycles (holdoff_cycles),
        .a12_in         (a12_in),
        .irq_n          (irq_n)
    );

    // Row: {hold-off, latch, line kinds (2 bits per line, line 1 lowest), expected firing line (0 = none)}
    // Kinds: 0 all low, 1 background rise, 2 sprite 4/4 burst, 3 one-cycle low glitch
    localparam int NROWS = 8;
    localparam logic [31:0] ROWS [NROWS] = '{
        {4'd8,  8'd3, 16'h5555, 4'd4},  // R5 background lines
        {4'd8,  8'd3, 16'hAAAA, 4'd4},  // R3 burst, one rise per line
        {4'd4,  8'd3, 16'hAAAA, 4'd1},  // R3 burst, all rises taken
        {4'd8,  8'd2, 16'h1111, 4'd5},  // R4 low lines between rises
        {4'd8,  8'd1, 16'h0000, 4'd0},  // R4 all low, never fires
        {4'd0,  8'd1, 16'hFFFF, 4'd2},  // R2 floor of two low samples
        {4'd8,  8'd0, 16'h5555, 4'd1},  // R6 latch zero fires at once
        {4'd15, 8'd1, 16'hAAAA, 4'd2}   // R2 largest hold-off
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic lvl(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            a12_in = v;
            @(negedge clk);
        end
    endtask

    task automatic run_line(input logic [1:0] k);
        case (k)
            2'd0: lvl(1'b0, 44);
            2'd1: begin lvl(1'b0, 12); lvl(1'b1, 4); lvl(1'b0, 28); end
            2'd2: begin
                lvl(1'b0, 12);
                for (int b = 0; b < 4; b++) begin lvl(1'b1, 4); lvl(1'b0, 4); end
            end
            default: begin
                lvl(1'b0, 12); lvl(1'b1, 3); lvl(1'b0, 1); lvl(1'b1, 3); lvl(1'b0, 25);
            end
        endcase
    endtask

    task automatic cpu_write(input logic [2:0] hi, input logic lo, input logic [7:0] d);
        cpu_we = 1'b1; cpu_addr_hi = hi; cpu_addr_lo = lo; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic do_reset(input logic a12_level);
        a12_in = a12_level;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic arm(input logic [7:0] latch_val, input logic en);
        cpu_write(3'b110, 1'b0, latch_val);
        cpu_write(3'b110, 1'b1, 8'h00);
        if (en) cpu_write(3'b111, 1'b1, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R8 reset state
        do_reset(1'b0);
        check("R8 irq_n after reset", irq_n, 1);

        for (int r = 0; r < NROWS; r++) begin
            int fired;
            holdoff_cycles = ROWS[r][31:28];
            do_reset(1'b0);
            arm(ROWS[r][27:20], 1'b1);
            fired = 0;
            for (int ln = 1; ln <= 8; ln++) begin
                run_line(ROWS[r][4 + 2*(ln-1) +: 2]);
                if (fired == 0 && irq_n == 1'b0) fired = ln;
            end
            check($sformatf("R3/R5 row %0d firing line", r), fired, int'(ROWS[r][3:0]));
        end

        // R6 held until acknowledge, R7 acknowledge clears
        holdoff_cycles = 4'd8;
        do_reset(1'b0);
        arm(8'd0, 1'b1);
        run_line(2'd1);
        check("R6 fires on zero", irq_n, 0);
        run_line(2'd0); run_line(2'd1);
        check("R6 held without ack", irq_n, 0);
        cpu_write(3'b111, 1'b0, 8'h00);
        check("R7 ack releases irq_n", irq_n, 1);

        // R9 zero while disabled raises nothing, later zero does
        do_reset(1'b0);
        arm(8'd1, 1'b0);
        run_line(2'd1); run_line(2'd1); run_line(2'd1);
        check("R9 disabled zero quiet", irq_n, 1);
        cpu_write(3'b111, 1'b1, 8'h00);
        run_line(2'd1);
        check("R9 enabled zero fires", irq_n, 0);

        // R5 reload request in the middle of a count
        do_reset(1'b0);
        arm(8'd5, 1'b1);
        run_line(2'd1); run_line(2'd1);
        cpu_write(3'b110, 1'b0, 8'd2);
        cpu_write(3'b110, 1'b1, 8'h00);
        run_line(2'd1); run_line(2'd1);
        check("R5 reload then one step", irq_n, 1);
        run_line(2'd1);
        check("R5 reload reaches zero", irq_n, 0);

        // R7 writes outside the register window are ignored
        do_reset(1'b0);
        cpu_write(3'b110, 1'b0, 8'd3);
        cpu_write(3'b110, 1'b1, 8'h00);
        cpu_write(3'b100, 1'b0, 8'd0);
        cpu_write(3'b101, 1'b1, 8'h00);
        cpu_write(3'b111, 1'b1, 8'h00);
        run_line(2'd1); run_line(2'd1); run_line(2'd1);
        check("R7 foreign writes ignored, not yet zero", irq_n, 1);
        run_line(2'd1);
        check("R7 count from latch 3", irq_n, 0);

        // R1/R4 long high and long low runs do not count
        do_reset(1'b0);
        arm(8'd0, 1'b1);
        lvl(1'b0, 2); lvl(1'b1, 1);
        lvl(1'b1, 40); lvl(1'b0, 40);
        check("R1 no rise without hold-off", irq_n, 1);

        // R8 hold-off history cleared by reset
        do_reset(1'b1);
        arm(8'd0, 1'b1);
        lvl(1'b0, 3); lvl(1'b1, 4);
        check("R8 short low after reset rejected", irq_n, 1);
        lvl(1'b0, 10); lvl(1'b1, 2);
        check("R2 full hold-off accepted", irq_n, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule